// File: doc/BRIEF.md
# Aligned Flash Row Write Collector

This block sits between a bus command decoder and a flash programming engine. It gathers bytes bound for flash and passes them on only as a whole 8-byte row that starts on an aligned address. The bytes can come as one block-write transfer of exactly eight beats, or as eight single-byte writes at consecutive addresses. When the row is complete, the block issues a one-cycle request that carries the aligned row address and a 64-bit data word. The byte at offset i within the row sits in bits 8i+7 down to 8i.

Bytes enter on a valid/ready stream. A beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` equals the inverse of `busy`, so the programming engine stalls the stream by raising `busy`. While a beat is stalled, the source must hold it and all of its fields steady. The request output has no back-pressure: it is a single-cycle pulse, and the engine is expected to raise `busy` while it programs.

A row in progress is dropped when the stream breaks the rules: a misaligned or out-of-range start, a skipped address, a block of the wrong length, or a mix of block and single beats. The block then pulses `err` for one cycle. Beats that belong to a rejected block are discarded up to its final beat, and they raise no further error.

Top module: `flash_row_gather`

## Requirements
- R1: `in_ready` is the inverse of `busy`. A beat presented while `busy` is high is not taken, and `req_valid` and `err` stay low in the cycle after it.
- R2: A row may start only at an address whose three low bits are 000. Any other starting address gives one `err` pulse and stores nothing.
- R3: A row may start only at an address from 200h to 28Fh, both included. A start outside that window gives one `err` pulse. The row at 288h is accepted.
- R4: Eight single beats (`in_blk`=0) at addresses base, base+1, …, base+7 give exactly one `req_valid` pulse, in the cycle right after the eighth beat is taken, with `req_addr` = base.
- R5: The byte of row offset i (single beat at base+i, or the i-th beat of a block counted from 0) appears in `req_data[8i+7:8i]`.
- R6: A block write is a run of beats with `in_blk`=1 whose first beat carries the row address and whose eighth and final beat has `in_last`=1. It gives one request. The addresses of its later beats are ignored.
- R7: During a single-beat row, a beat at any address other than the next consecutive one gives one `err` pulse. That beat and the partial row are dropped, and a later aligned beat starts a fresh row.
- R8: A block whose `in_last` arrives before its eighth beat (a length of 1 to 7) gives one `err` pulse and no request.
- R9: A block whose eighth beat lacks `in_last` gives one `err` pulse on that beat and no request. Its remaining beats, up to and including the one with `in_last`, are discarded without further error.
- R10: A single beat inside a block row, or a block beat inside a single-beat row, gives one `err` pulse and drops the partial row. If the intruding beat opens a longer block, the rest of that block is discarded as in R9.
- R11: After reset, `req_valid` and `err` are low. Each is a one-cycle pulse, and they are never high together.
- R12: A new row's first beat may be taken in the same cycle that `req_valid` is high, so back-to-back rows need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat present |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_addr | input | 10 | Flash byte address of the beat (used on the first beat of a block) |
| in_data | input | 8 | Byte value |
| in_blk | input | 1 | Beat belongs to a block write |
| in_last | input | 1 | Final beat of a block write |
| busy | input | 1 | Programming engine occupied; stalls the stream |
| req_valid | output | 1 | One-cycle row write request |
| req_addr | output | 10 | Aligned row address, valid with `req_valid` |
| req_data | output | 64 | Row data, byte offset i in bits 8i+7:8i |
| err | output | 1 | One-cycle pulse when a beat or a row is rejected |

## Verification
Completing one row and starting the next can fall in the same cycle. Two blocks are driven back to back with `in_valid` held high, so the first beat of the second row is taken while `req_valid` for the first row is up. A behavioural model is checked on every clock. It shows that the request still carries the first row's address and bytes, and that the second row completes eight cycles later. A second pair of functions can also coincide: a stall and a beat. `busy` toggles periodically in the middle of a single-beat row, and each stalled cycle is judged on `in_ready` and on the absence of any pulse that follows it.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_FILL = 2'd1,
    GS_SKIP = 2'd2
  } gath_state_t;
endpackage

// File: rtl/row_beat_check.sv
module row_beat_check #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] LO_ADDR = 10'h200,
  parameter logic [ADDR_W-1:0] HI_ADDR = 10'h28F
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-IDX_W-1:0] base,
  input  logic [IDX_W-1:0]        cnt,
  output logic                    aligned,
  output logic                    in_range,
  output logic                    seq_ok
);
  // Row starts need zero offset bits.
  assign aligned  = (addr[IDX_W-1:0] == '0);
  assign in_range = (addr >= LO_ADDR) && (addr <= HI_ADDR);
  // The next single beat must hit the offset equal to the bytes held so far.
  assign seq_ok   = (addr == {base, cnt});
endmodule

// File: rtl/row_lanes.sv
module row_lanes #(
  parameter int ROW_BYTES = 8,
  parameter int IDX_W     = $clog2(ROW_BYTES),
  localparam int ROW_W    = 8 * ROW_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  output logic [ROW_W-1:0] row_q
);
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        row_q[8*g +: 8] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        row_q[8*g +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/flash_row_gather.sv
module flash_row_gather #(
  parameter int ADDR_W    = 10,
  parameter int ROW_BYTES = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 10'h200,
  parameter logic [ADDR_W-1:0] HI_ADDR = 10'h28F,
  localparam int IDX_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int BASE_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_data,
  input  logic              in_blk,
  input  logic              in_last,
  input  logic              busy,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ROW_W-1:0]  req_data,
  output logic              err
);
  import flash_row_pkg::*;

  gath_state_t       state, nxt_state;
  logic [IDX_W-1:0]  cnt, nxt_cnt;
  logic [BASE_W-1:0] base, nxt_base;
  logic              mode_blk, nxt_blk;
  logic              lane_we;
  logic [IDX_W-1:0]  lane_idx;
  logic              commit, fault;
  logic              aligned, in_range, seq_ok;
  logic              acc, last_idx, beat_ok;

  assign in_ready = !busy;
  assign acc      = in_valid && in_ready;
  assign last_idx = (cnt == IDX_W'(ROW_BYTES - 1));
  assign beat_ok  = mode_blk ? (in_blk && (in_last == last_idx))
                             : (!in_blk && seq_ok);

  row_beat_check #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_chk (
    .addr(in_addr), .base(base), .cnt(cnt),
    .aligned(aligned), .in_range(in_range), .seq_ok(seq_ok)
  );

  row_lanes #(.ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .wr_en(lane_we), .wr_idx(lane_idx),
    .wr_byte(in_data), .row_q(req_data)
  );

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    nxt_base  = base;
    nxt_blk   = mode_blk;
    lane_we   = 1'b0;
    lane_idx  = cnt;
    commit    = 1'b0;
    fault     = 1'b0;
    if (acc) begin
      if (state == GS_SKIP && in_blk) begin
        // Tail of a rejected block: drop silently until its final beat.
        if (in_last) nxt_state = GS_IDLE;
      end else if (state != GS_FILL) begin
        nxt_state = GS_IDLE;
        if (!aligned || !in_range || (in_blk && in_last)) begin
          fault = 1'b1;
          if (in_blk && !in_last) nxt_state = GS_SKIP;
        end else begin
          lane_we   = 1'b1;
          lane_idx  = '0;
          nxt_cnt   = IDX_W'(1);
          nxt_base  = in_addr[ADDR_W-1:IDX_W];
          nxt_blk   = in_blk;
          nxt_state = GS_FILL;
        end
      end else if (!beat_ok) begin
        fault     = 1'b1;
        nxt_cnt   = '0;
        nxt_state = (in_blk && !in_last) ? GS_SKIP : GS_IDLE;
      end else begin
        lane_we = 1'b1;
        if (last_idx) begin
          commit    = 1'b1;
          nxt_cnt   = '0;
          nxt_state = GS_IDLE;
        end else begin
          nxt_cnt = cnt + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= GS_IDLE;
      cnt       <= '0;
      base      <= '0;
      mode_blk  <= 1'b0;
      req_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      state     <= nxt_state;
      cnt       <= nxt_cnt;
      base      <= nxt_base;
      mode_blk  <= nxt_blk;
      req_valid <= commit;
      err       <= fault;
    end
  end

  // Base only moves when a new row starts, which is never the commit edge.
  assign req_addr = {base, {IDX_W{1'b0}}};
endmodule

// File: rtl/flash_row_gather_sva.sv
module flash_row_gather_sva #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] LO_ADDR = 10'h200,
  parameter logic [ADDR_W-1:0] HI_ADDR = 10'h28F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              in_ready,
  input logic              req_valid,
  input logic              err,
  input logic [ADDR_W-1:0] req_addr
);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && err));

  // R11
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R1
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_ready) |=> (!req_valid && !err));

  // R2
  row_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[IDX_W-1:0] == '0));

  // R3
  row_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr >= LO_ADDR && req_addr <= HI_ADDR));
endmodule

bind flash_row_gather flash_row_gather_sva #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_ready(in_ready),
  .req_valid(req_valid), .err(err), .req_addr(req_addr)
);

// File: tb/sim_flash_row_gather.sv
module sim_flash_row_gather;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_blk, in_last, busy;
  logic [9:0]  in_addr;
  logic [7:0]  in_data;
  logic        in_ready, req_valid, err;
  logic [9:0]  req_addr;
  logic [63:0] req_data;

  int    checks = 0, errors = 0, cyc = 0, reqs_seen = 0;
  bit    done = 1'b0, stall_en = 1'b0;
  string cur_req = "R11";

  // reference model state
  byte unsigned q[$];
  int    row_base = 0;
  bit    blk_mode = 1'b0, skipping = 1'b0;
  bit    exp_req = 1'b0, exp_err = 1'b0;
  logic [9:0]  exp_addr = '0;
  logic [63:0] exp_data = '0;

  flash_row_gather u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_blk(in_blk), .in_last(in_last),
    .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .err(err)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n && !done) chk(in_ready == !busy, "in_ready (R1)", 64'(in_ready), 64'(!busy));
    exp_req = 1'b0;
    exp_err = 1'b0;
    if (!rst_n) begin
      q.delete();
      skipping = 1'b0;
    end else if (in_valid && !busy) begin
      if (skipping && in_blk) begin
        if (in_last) skipping = 1'b0;
      end else begin
        skipping = 1'b0;
        if (q.size() == 0) begin
          if ((in_addr % 8) != 0 || in_addr < 10'h200 || in_addr > 10'h28F ||
              (in_blk && in_last)) begin
            exp_err  = 1'b1;
            skipping = in_blk && !in_last;
          end else begin
            q.push_back(in_data);
            row_base = int'(in_addr);
            blk_mode = in_blk;
          end
        end else begin
          bit ok;
          if (blk_mode) ok = in_blk && (in_last == (q.size() == 7));
          else          ok = !in_blk && (int'(in_addr) == row_base + q.size());
          if (!ok) begin
            exp_err  = 1'b1;
            q.delete();
            skipping = in_blk && !in_last;
          end else begin
            q.push_back(in_data);
            if (q.size() == 8) begin
              exp_req  = 1'b1;
              exp_addr = 10'(row_base);
              for (int i = 0; i < 8; i++) exp_data[8*i +: 8] = q[i];
              q.delete();
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_valid == exp_req, "req_valid", 64'(req_valid), 64'(exp_req));
      chk(err == exp_err, "err", 64'(err), 64'(exp_err));
      if (exp_req) begin
        chk(req_addr == exp_addr, "req_addr", 64'(req_addr), 64'(exp_addr));
        chk(req_data == exp_data, "req_data", req_data, exp_data);
      end
      if (req_valid) reqs_seen++;
    end
    busy <= stall_en && (cyc % 3 == 1);
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      errors++;
      done = 1'b1;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic beat(input logic [9:0] a, input logic [7:0] d,
                      input bit b, input bit l);
    in_valid = 1'b1; in_addr = a; in_data = d; in_blk = b; in_last = l;
    @(posedge clk);
    while (busy) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_blk = 1'b0; in_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic singles(input logic [9:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) beat(a + 10'(i), seed + 8'(i * 17), 1'b0, 1'b0);
  endtask

  task automatic block(input logic [9:0] a, input int n, input bit mark_end,
                       input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      beat(i == 0 ? a : 10'h3FF - 10'(i), seed ^ 8'(i * 29), 1'b1,
           mark_end && (i == n - 1));
  endtask

  initial begin
    int r0;
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0;
    in_blk = 1'b0; in_last = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_valid == 1'b0, "reset req_valid", 64'(req_valid), 64'd0);
    chk(err == 1'b0, "reset err", 64'(err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R4 R5 R1";          // singles with periodic stalls
    stall_en = 1'b1;
    singles(10'h200, 8, 8'h11);
    idle(4);
    stall_en = 1'b0;
    idle(2);

    cur_req = "R6 R5";             // block, later addresses ignored
    block(10'h248, 8, 1'b1, 8'hA5);
    idle(3);

    cur_req = "R2";                // misaligned starts
    beat(10'h203, 8'h01, 1'b0, 1'b0);
    idle(2);
    block(10'h20C, 4, 1'b1, 8'h33);
    idle(2);

    cur_req = "R3";                // window edges
    singles(10'h1F8, 1, 8'h44);
    idle(1);
    singles(10'h290, 1, 8'h45);
    idle(1);
    singles(10'h288, 8, 8'h46);
    idle(3);

    cur_req = "R7";                // sequence break, then fresh row
    singles(10'h210, 2, 8'h50);
    beat(10'h213, 8'h99, 1'b0, 1'b0);
    idle(2);
    singles(10'h218, 8, 8'h60);
    idle(3);

    cur_req = "R8";                // short block
    block(10'h230, 5, 1'b1, 8'h70);
    idle(3);

    cur_req = "R9";                // over-long block, tail discarded
    block(10'h238, 10, 1'b1, 8'h80);
    idle(3);

    cur_req = "R10";               // block intruding a single row, and reverse
    singles(10'h220, 2, 8'h90);
    block(10'h240, 3, 1'b1, 8'h91);
    idle(2);
    block(10'h250, 3, 1'b0, 8'h92);
    beat(10'h253, 8'h93, 1'b0, 1'b0);
    idle(3);

    cur_req = "R12";               // back-to-back rows
    r0 = reqs_seen;
    block(10'h260, 8, 1'b1, 8'hC3);
    block(10'h268, 8, 1'b1, 8'h3C);
    singles(10'h270, 8, 8'h07);
    idle(4);
    chk(reqs_seen - r0 == 3, "rows committed (R12)", 64'(reqs_seen - r0), 64'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule